// File: doc/BRIEF.md
# Capability CSR Address Width Modulator

This block holds the address field, tag and sealed bit of one capability-extended control register, such as a trap-vector, scratch or exception-return capability. The privilege mode that owns the register can run with different address widths. When software writes the register, the surrounding logic also supplies a precomputed verdict: would this value still be representable once it is cut down to the narrower width? The block stores that verdict as a flag next to the value.

When a width-change strobe arrives and the new width is smaller than the old one, the block cuts the stored address down to the new width and fills the upper bits with zeros. It does not sign-extend, which is different from how the program counter is handled. In the same step the block decides whether to clear the tag. It uses the stored verdict and a comparison between the original and the cut-down address, which only matters when the register is sealed. Widening, and a strobe that leaves the width the same, change nothing.

Top module: `xcsr_width_mod`

## Requirements
- R1: After reset the address output is zero, and both the tag and sealed outputs are 0.
- R2: A write (`wr_en_i`=1) loads `wr_addr_i`, `wr_tag_i` and `wr_sealed_i`, which are visible on the outputs in the next cycle. It also stores `wr_repr_ok_i` as the representability flag.
- R3: A width code c (2 bits) selects the width 16<<c: code 0 is 16, 1 is 32, 2 is 64 and 3 is 128. Any width above `XLEN_MAX` is clamped to `XLEN_MAX`.
- R4: On a strobe (`wchg_i`=1, no write) where the new width is smaller than the old one, the address becomes the stored address masked to its low new-width bits. All bits above that width become 0, including when the bit just below the cut is 1.
- R5: On a strobe where the new width is greater than or equal to the old width, the address and tag keep their values.
- R6: On a narrowing strobe, the tag is cleared if the stored representability flag is 0.
- R7: On a narrowing strobe, the tag is cleared if the register is sealed and the truncated address differs from the stored address.
- R8: On a narrowing strobe where neither R6 nor R7 applies, the tag keeps its value. A strobe never sets the tag.
- R9: A strobe never changes the sealed bit.
- R10: When a write and a strobe happen in the same cycle, only the write takes effect.
- R11: Every write replaces the representability flag, and only the most recent write's flag decides the outcome at the next narrowing strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | XLEN_MAX | Address value to write |
| wr_tag_i | input | 1 | Tag value to write |
| wr_sealed_i | input | 1 | Sealed state to write |
| wr_repr_ok_i | input | 1 | Precomputed: value stays representable after truncation |
| xlen_old_i | input | 2 | Width code in force before the change |
| xlen_new_i | input | 2 | Width code after the change |
| wchg_i | input | 1 | Width-change strobe |
| addr_o | output | XLEN_MAX | Stored address field |
| tag_o | output | 1 | Stored tag |
| sealed_o | output | 1 | Stored sealed state |

## Verification
The assertions assume that `xlen_old_i` and `xlen_new_i` are stable and meaningful whenever `wchg_i` is high. They also assume that `wr_repr_ok_i` is a valid verdict whenever `wr_en_i` is high. The bench drives every input only at falling edges. It holds the width codes constant around each strobe and sweeps all sixteen old/new code pairs. Each pair is combined with every sealed, tag and flag combination and three address patterns. The patterns are chosen to straddle the 16-bit and 32-bit cut points.

// File: rtl/xcsr_width_pkg.sv
package xcsr_width_pkg;

  // Width selected by a 2-bit code, clamped to the widest supported width.
  function automatic int unsigned code_to_width(input logic [1:0] code,
                                                input int unsigned max_w);
    int unsigned w;
    w = 32'd16 << code;
    if (w > max_w) w = max_w;
    return w;
  endfunction

  // New tag after a narrowing step.
  function automatic logic narrowed_tag(input logic tag,
                                        input logic repr_ok,
                                        input logic sealed,
                                        input logic differs);
    return tag & repr_ok & ~(sealed & differs);
  endfunction

endpackage

// File: rtl/xcsr_width_cmp.sv
module xcsr_width_cmp #(
  parameter int unsigned XLEN_MAX = 64,
  localparam int WW = $clog2(XLEN_MAX + 1)
) (
  input  logic [1:0]    old_code_i,
  input  logic [1:0]    new_code_i,
  output logic [WW-1:0] new_width_o,
  output logic          narrow_o
);
  import xcsr_width_pkg::*;

  int unsigned w_old;
  int unsigned w_new;

  always_comb begin
    w_old       = code_to_width(old_code_i, XLEN_MAX);
    w_new       = code_to_width(new_code_i, XLEN_MAX);
    new_width_o = WW'(w_new);
    narrow_o    = (w_new < w_old);
  end
endmodule

// File: rtl/xcsr_width_trunc.sv
module xcsr_width_trunc #(
  parameter int unsigned XLEN_MAX = 64,
  localparam int WW = $clog2(XLEN_MAX + 1)
) (
  input  logic [XLEN_MAX-1:0] addr_i,
  input  logic [WW-1:0]       width_i,
  output logic [XLEN_MAX-1:0] mask_o,
  output logic [XLEN_MAX-1:0] trunc_o,
  output logic                differs_o
);
  always_comb begin
    for (int i = 0; i < int'(XLEN_MAX); i++) begin
      mask_o[i] = (i < int'(width_i));
    end
    trunc_o   = addr_i & mask_o;
    differs_o = (trunc_o != addr_i);
  end
endmodule

// File: rtl/xcsr_width_mod.sv
module xcsr_width_mod #(
  parameter int unsigned XLEN_MAX = 64,
  localparam int WW = $clog2(XLEN_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [XLEN_MAX-1:0] wr_addr_i,
  input  logic                wr_tag_i,
  input  logic                wr_sealed_i,
  input  logic                wr_repr_ok_i,
  input  logic [1:0]          xlen_old_i,
  input  logic [1:0]          xlen_new_i,
  input  logic                wchg_i,
  output logic [XLEN_MAX-1:0] addr_o,
  output logic                tag_o,
  output logic                sealed_o
);
  import xcsr_width_pkg::*;

  logic [XLEN_MAX-1:0] addr_q;
  logic                tag_q;
  logic                sealed_q;
  logic                repr_q;

  logic [WW-1:0]       new_width;
  logic                narrow;
  logic [XLEN_MAX-1:0] trunc_mask;
  logic [XLEN_MAX-1:0] trunc_addr;
  logic                trunc_differs;

  // Named events for the assertions.
  logic                ev_narrow_step;
  logic                ev_idle_strobe;

  xcsr_width_cmp #(.XLEN_MAX(XLEN_MAX)) u_cmp (
    .old_code_i (xlen_old_i),
    .new_code_i (xlen_new_i),
    .new_width_o(new_width),
    .narrow_o   (narrow)
  );

  xcsr_width_trunc #(.XLEN_MAX(XLEN_MAX)) u_trunc (
    .addr_i   (addr_q),
    .width_i  (new_width),
    .mask_o   (trunc_mask),
    .trunc_o  (trunc_addr),
    .differs_o(trunc_differs)
  );

  assign ev_narrow_step = wchg_i & ~wr_en_i & narrow;
  assign ev_idle_strobe = wchg_i & ~wr_en_i & ~narrow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      tag_q    <= 1'b0;
      sealed_q <= 1'b0;
      repr_q   <= 1'b0;
    end else if (wr_en_i) begin
      addr_q   <= wr_addr_i;
      tag_q    <= wr_tag_i;
      sealed_q <= wr_sealed_i;
      repr_q   <= wr_repr_ok_i;
    end else if (ev_narrow_step) begin
      addr_q   <= trunc_addr;
      tag_q    <= narrowed_tag(tag_q, repr_q, sealed_q, trunc_differs);
    end
  end

  assign addr_o   = addr_q;
  assign tag_o    = tag_q;
  assign sealed_o = sealed_q;

  // R10: a write wins over a same-cycle strobe.
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (addr_o == $past(wr_addr_i)) && (tag_o == $past(wr_tag_i)));

  // R5: non-narrowing strobe holds address and tag.
  a_r5_widen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle_strobe |=> $stable(addr_o) && $stable(tag_o));

  // R4: bits above the new width are zero after narrowing.
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_narrow_step |=> ((addr_o & ~$past(trunc_mask)) == '0));

  // R8: a strobe never raises the tag.
  a_r8_no_tag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wchg_i && !wr_en_i) |=> !$rose(tag_o));

  // R9: a strobe never touches the sealed bit.
  a_r9_sealed_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wchg_i && !wr_en_i) |=> $stable(sealed_o));

  // R6: a cleared flag kills the tag on narrowing.
  a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_narrow_step && !repr_q) |=> !tag_o);
endmodule

// File: tb/xcsr_width_mod_tb.sv
module xcsr_width_mod_tb;
  localparam int unsigned XM = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [XM-1:0] wr_addr_i = '0;
  logic          wr_tag_i = 1'b0;
  logic          wr_sealed_i = 1'b0;
  logic          wr_repr_ok_i = 1'b0;
  logic [1:0]    xlen_old_i = 2'd0;
  logic [1:0]    xlen_new_i = 2'd0;
  logic          wchg_i = 1'b0;
  logic [XM-1:0] addr_o;
  logic          tag_o;
  logic          sealed_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xcsr_width_mod #(.XLEN_MAX(XM)) u_dut (.*);

  task automatic check(input bit ok, input string req,
                       input logic [XM-1:0] act, input logic [XM-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bench_width(input int code);
    int w;
    w = 16 * (1 << code);
    return (w > int'(XM)) ? int'(XM) : w;
  endfunction

  function automatic logic [XM-1:0] bench_cut(input logic [XM-1:0] a, input int w);
    if (w >= int'(XM)) return a;
    return (a << (int'(XM) - w)) >> (int'(XM) - w);
  endfunction

  task automatic do_write(input logic [XM-1:0] a, input logic t, input logic s,
                          input logic r);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_tag_i = t; wr_sealed_i = s; wr_repr_ok_i = r;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_strobe(input int o, input int n);
    @(negedge clk);
    xlen_old_i = 2'(o); xlen_new_i = 2'(n); wchg_i = 1'b1;
    @(negedge clk);
    wchg_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [XM-1:0] pats [3];
    pats[0] = 64'hFFFF_FFFF_8000_9234;
    pats[1] = 64'h0000_0000_0000_1234;
    pats[2] = 64'h0000_0000_8765_4321;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(addr_o == '0, "R1", addr_o, '0);
    check(tag_o == 1'b0 && sealed_o == 1'b0, "R1", {tag_o, sealed_o}, '0);
    rst_n = 1'b1;

    for (int o = 0; o < 4; o++)
      for (int n = 0; n < 4; n++)
        for (int p = 0; p < 3; p++)
          for (int bits = 0; bits < 8; bits++) begin
            logic t, s, r, nar, diff, exp_tag;
            logic [XM-1:0] a, exp_a;
            t = bits[0]; s = bits[1]; r = bits[2];
            a = pats[p];
            do_write(a, t, s, r);
            check(addr_o == a && tag_o == t && sealed_o == s, "R2", addr_o, a);
            do_strobe(o, n);
            nar = bench_width(n) < bench_width(o);
            exp_a = nar ? bench_cut(a, bench_width(n)) : a;
            diff = (exp_a != a);
            exp_tag = nar ? (t && r && !(s && diff)) : t;
            check(addr_o == exp_a, nar ? "R3/R4" : "R3/R5", addr_o, exp_a);
            check(tag_o == exp_tag,
                  !nar ? "R5" : (!r ? "R6" : ((s && diff) ? "R7" : "R8")),
                  XM'(tag_o), XM'(exp_tag));
            check(sealed_o == s, "R9", XM'(sealed_o), XM'(s));
          end

    // R10: write and narrowing strobe together
    do_write(64'hFFFF_0000_0000_0001, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 64'hAAAA_BBBB_CCCC_DDDD; wr_tag_i = 1'b1;
    wr_sealed_i = 1'b1; wr_repr_ok_i = 1'b0;
    xlen_old_i = 2'd2; xlen_new_i = 2'd0; wchg_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wchg_i = 1'b0;
    check(addr_o == 64'hAAAA_BBBB_CCCC_DDDD, "R10", addr_o, 64'hAAAA_BBBB_CCCC_DDDD);
    check(tag_o == 1'b1 && sealed_o == 1'b1, "R10", {tag_o, sealed_o}, 2'b11);

    // R11: later write's flag replaces earlier one
    do_write(64'h0000_0000_0000_00FF, 1'b1, 1'b0, 1'b0);
    do_write(64'h0000_0000_0000_00FF, 1'b1, 1'b0, 1'b1);
    do_strobe(2, 1);
    check(tag_o == 1'b1, "R11", XM'(tag_o), XM'(1));
    do_write(64'h0000_0000_0000_00FF, 1'b1, 1'b0, 1'b1);
    do_write(64'h0000_0000_0000_00FF, 1'b1, 1'b0, 1'b0);
    do_strobe(2, 1);
    check(tag_o == 1'b0, "R11", XM'(tag_o), XM'(0));

    // R4: zero, not sign, extension at bit 31
    do_write(64'h0000_0000_8000_0000, 1'b1, 1'b0, 1'b1);
    do_strobe(3, 1);
    check(addr_o == 64'h0000_0000_8000_0000, "R4", addr_o, 64'h0000_0000_8000_0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule